// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable synchronous SRAM with a parameterized depth and a 32-bit word made of four 8-bit byte lanes. Read data leaves the block two active clock edges after the read command is loaded. Write data is taken two active edges after the write command, address and byte enables. Because the read and write delays are equal, commands of either kind can follow one another on every cycle with no idle slot on the data buses.

A small controller decodes each cycle. Its state machine has three states: `ST_DESEL`, `ST_READ` and `ST_WRITE`. Each state records the operation loaded last. There are four transitions. `LOAD_DESEL` is taken on a load with any chip enable inactive. `LOAD_READ` is taken on a load with all enables active and `rd_wr_n` high. `LOAD_WRITE` is taken on a load with all enables active and `rd_wr_n` low. `ADVANCE` is taken when `adv` is high and keeps the current state. On an advance cycle the block repeats the last loaded operation at the address on `addr`, which an external burst sequencer supplies. A two-stage command pipeline carries the operation, address and byte enables. A read that overtakes a write still in flight receives that write's bytes, merged lane by lane with the array contents. When `hold` is high the whole block is frozen. The read and write data buses are separate. A driven/valid pair stands in for the tri-state output drivers.

Top module: `zt_sram`

## Requirements
- R1: A read loaded at active edge k presents its data on `rdata` with `rdata_vld` high after active edge k+2. Edges with `hold` high are not counted.
- R2: A write registers `addr` and `be_n` at its load edge k. It samples `wdata` at active edge k+2 and stores it in the array.
- R3: Reads and writes, in any order, are accepted on consecutive cycles. Each read returns the result of all earlier commands, and no idle cycle is needed.
- R4: `be_n[i]` is active low and enables bits [8i+7:8i]. All four low writes the full word. All four high leaves the word unchanged.
- R5: With `hold` high at an edge, no register changes. The outputs and pipeline keep their values, and inputs at that edge (including a write command) are ignored.
- R6: A load (`adv` low) with `ce0_n` high, `ce1` low or `ce2_n` high issues no operation. `rdata_vld` stays low for the slot of that command, while commands already in flight still complete.
- R7: `rd_wr_n` and the chip enables are used only on load cycles. With `adv` high the last loaded operation (read, write or none) repeats at the address on `addr`, and `be_n` is used on each write cycle.
- R8: `oe_n` acts asynchronously on the output only. When it is high, `dq_drive` is low and `rdata` is zero. `rdata_vld` and the pipeline are unaffected. `dq_drive` is high only while `rdata_vld` is high and `oe_n` is low.
- R9: A read loaded one cycle after a write to the same address returns the new bytes in the written lanes and the old array bytes in the other lanes.
- R10: After reset `rdata_vld` and `dq_drive` are low, `rdata` is zero and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold | input | 1 | Freeze: high masks the clock edge |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| adv | input | 1 | High: advance (repeat last op); low: load new command |
| rd_wr_n | input | 1 | On load: high read, low write |
| be_n | input | 4 | Byte-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data, sampled two active edges after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 32 | Read data, zero when not driven |
| rdata_vld | output | 1 | Read data present in this cycle |
| dq_drive | output | 1 | Output drivers enabled |

## Verification
All results are due after a count of active edges. Read data is due two active edges after its load edge, and write data is consumed at that same later edge. The bench counts only edges with `hold` low. At issue time it stamps each expected read with the due count and schedules each write's data for its due count. The monitor samples one nanosecond after every edge. It pops an entry only when the active count equals the stamp. It requires `rdata_vld` low in every other active slot and unchanged outputs after every held edge.

// File: rtl/zt_pkg.sv
`timescale 1ns/1ps
package zt_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } st_e;
endpackage

// File: rtl/zt_ctrl.sv
`timescale 1ns/1ps
module zt_ctrl
    import zt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic adv,
    input  logic ce0_n,
    input  logic ce1,
    input  logic ce2_n,
    input  logic rd_wr_n,
    output op_e  issue_op
);
    st_e  state_q;
    st_e  state_d;
    logic sel;

    assign sel = !ce0_n && ce1 && !ce2_n;

    // Next state: LOAD_DESEL, LOAD_READ, LOAD_WRITE or ADVANCE (hold state)
    always_comb begin
        state_d = state_q;
        if (!adv) begin
            if (!sel)         state_d = ST_DESEL;
            else if (rd_wr_n) state_d = ST_READ;
            else              state_d = ST_WRITE;
        end
    end

    // State register, frozen while hold is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= ST_DESEL;
        else if (!hold) state_q <= state_d;
    end

    // Output: operation issued into the pipeline this cycle
    always_comb begin
        unique case (state_d)
            ST_DESEL: issue_op = OP_NONE;
            ST_READ:  issue_op = OP_READ;
            ST_WRITE: issue_op = OP_WRITE;
            default:  issue_op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/zt_pipe.sv
`timescale 1ns/1ps
module zt_pipe
    import zt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  op_e               in_op,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_be_n,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output op_e               s2_op,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [LANES-1:0]  s2_be_n
);
    localparam int STAGES = 2;

    op_e               op_q   [STAGES];
    logic [ADDR_W-1:0] addr_q [STAGES];
    logic [LANES-1:0]  be_q   [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) op_q[i] <= OP_NONE;
        end else if (!hold) begin
            op_q[0] <= in_op;
            for (int i = 1; i < STAGES; i++) op_q[i] <= op_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!hold) begin
            addr_q[0] <= in_addr;
            be_q[0]   <= in_be_n;
            for (int i = 1; i < STAGES; i++) begin
                addr_q[i] <= addr_q[i-1];
                be_q[i]   <= be_q[i-1];
            end
        end
    end

    assign s1_op   = op_q[0];
    assign s1_addr = addr_q[0];
    assign s2_op   = op_q[STAGES-1];
    assign s2_addr = addr_q[STAGES-1];
    assign s2_be_n = be_q[STAGES-1];
endmodule

// File: rtl/zt_mem.sv
`timescale 1ns/1ps
module zt_mem
    import zt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              hold,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_be_n,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] fetch_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] fwd;
    logic              same;

    assign same = wr_en && (wr_addr == rd_addr);

    // Per-lane forwarding of the write committing at this same edge
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign fwd[g*LANE_W +: LANE_W] = (same && !wr_be_n[g])
                                       ? wdata[g*LANE_W +: LANE_W]
                                       : mem[rd_addr][g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (!hold && wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (!wr_be_n[i]) mem[wr_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!hold && rd_en) fetch_q <= fwd;
    end
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
    import zt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              ce2_n,
    input  logic              adv,
    input  logic              rd_wr_n,
    input  logic [3:0]        be_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              oe_n,
    output logic [31:0]       rdata,
    output logic              rdata_vld,
    output logic              dq_drive
);
    op_e               issue_op;
    op_e               s1_op;
    op_e               s2_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_be_n;
    logic [WORD_W-1:0] fetch_q;
    logic [WORD_W-1:0] data_q;
    logic              vld_q;

    zt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .adv      (adv),
        .ce0_n    (ce0_n),
        .ce1      (ce1),
        .ce2_n    (ce2_n),
        .rd_wr_n  (rd_wr_n),
        .issue_op (issue_op)
    );

    zt_pipe #(.ADDR_W(ADDR_W)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .in_op   (issue_op),
        .in_addr (addr),
        .in_be_n (be_n),
        .s1_op   (s1_op),
        .s1_addr (s1_addr),
        .s2_op   (s2_op),
        .s2_addr (s2_addr),
        .s2_be_n (s2_be_n)
    );

    zt_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .hold    (hold),
        .wr_en   (s2_op == OP_WRITE),
        .wr_addr (s2_addr),
        .wr_be_n (s2_be_n),
        .wdata   (wdata),
        .rd_en   (s1_op == OP_READ),
        .rd_addr (s1_addr),
        .fetch_q (fetch_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            data_q <= '0;
        end else if (!hold) begin
            vld_q <= (s2_op == OP_READ);
            if (s2_op == OP_READ) data_q <= fetch_q;
        end
    end

    assign rdata_vld = vld_q;
    assign dq_drive  = vld_q && !oe_n;
    assign rdata     = dq_drive ? data_q : '0;
endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk
    import zt_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic hold,
    input logic adv,
    input logic ce0_n,
    input logic ce1,
    input logic ce2_n,
    input logic oe_n,
    input logic rdata_vld,
    input logic dq_drive,
    input op_e  s1_op,
    input op_e  s2_op
);
    AST_READ_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && s2_op == OP_READ) |=> rdata_vld); // R1

    AST_NOOP_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && s2_op == OP_NONE) |=> !rdata_vld); // R6

    AST_DESELECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !adv && (ce0_n || !ce1 || ce2_n)) |=> (s1_op == OP_NONE)); // R6

    AST_PIPE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> (s2_op == $past(s1_op))); // R3

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(rdata_vld) && $stable(s1_op) && $stable(s2_op))); // R5

    AST_ADVANCE_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && adv) |=> (s1_op == $past(s1_op))); // R7

    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_drive); // R8

    AST_DRIVE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> rdata_vld); // R8
endmodule

bind zt_sram zt_sram_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .adv       (adv),
    .ce0_n     (ce0_n),
    .ce1       (ce1),
    .ce2_n     (ce2_n),
    .oe_n      (oe_n),
    .rdata_vld (rdata_vld),
    .dq_drive  (dq_drive),
    .s1_op     (s1_op),
    .s2_op     (s2_op)
);

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          hold;
    logic          ce0_n, ce1, ce2_n;
    logic          adv;
    logic          rd_wr_n;
    logic [3:0]    be_n;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic          oe_n;
    logic [31:0]   rdata;
    logic          rdata_vld;
    logic          dq_drive;

    always #2.5 clk = ~clk;

    zt_sram #(.ADDR_W(AW)) u_zt_sram (
        .clk(clk), .rst_n(rst_n), .hold(hold), .ce0_n(ce0_n), .ce1(ce1),
        .ce2_n(ce2_n), .adv(adv), .rd_wr_n(rd_wr_n), .be_n(be_n),
        .addr(addr), .wdata(wdata), .oe_n(oe_n), .rdata(rdata),
        .rdata_vld(rdata_vld), .dq_drive(dq_drive)
    );

    typedef struct { int due; logic [31:0] data; } exp_t;
    exp_t        sb [$];
    logic [31:0] model  [int];
    logic [31:0] wsched [int];
    int  act_cnt = 0;
    bit  last_act = 0;
    int  last_op = 0;   // 0 none, 1 read, 2 write
    int  n_chk = 0;
    int  n_bad = 0;

    always @(posedge clk) begin
        if (rst_n && !hold) begin act_cnt++; last_act = 1; end
        else last_act = 0;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ce = {ce0_n, ce1, ce2_n}; 3'b010 selects the device
    task automatic cyc(input bit hld, input bit ld, input logic [2:0] ce, input bit rd,
                       input logic [3:0] be, input int a, input logic [31:0] d);
        int nxt;
        int op;
        @(negedge clk);
        nxt = act_cnt + 1;
        hold = hld; adv = !ld; {ce0_n, ce1, ce2_n} = ce; rd_wr_n = rd;
        be_n = be; addr = a[AW-1:0];
        wdata = wsched.exists(nxt) ? wsched[nxt] : (32'h5A5A_0000 ^ nxt);
        if (!hld) begin
            if (ld) begin
                op = (ce != 3'b010) ? 0 : (rd ? 1 : 2);
                last_op = op;
            end else op = last_op;
            if (op == 2) begin
                logic [31:0] w;
                w = model.exists(a) ? model[a] : '0;
                for (int i = 0; i < 4; i++) if (!be[i]) w[i*8 +: 8] = d[i*8 +: 8];
                model[a] = w;
                wsched[nxt + 2] = d;
            end
            if (op == 1) sb.push_back('{nxt + 2, model[a]});
        end
    endtask

    task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
        cyc(0, 1, 3'b010, 0, be, a, d);
    endtask
    task automatic rd(input int a);
        cyc(0, 1, 3'b010, 1, 4'hF, a, 32'h0);
    endtask
    task automatic idle();
        cyc(0, 1, 3'b110, 1, 4'hF, 0, 32'h0);
    endtask
    task automatic stall();
        cyc(1, 1, 3'b010, 0, 4'h0, 7, 32'hBAD0_BAD0);   // R5: a write command that must be ignored
    endtask

    // Monitor: scoreboard pop at the due active edge
    initial begin
        logic        prev_v;
        logic [31:0] prev_d;
        prev_v = 0; prev_d = 0;
        forever begin
            @(posedge clk); #1;
            if (rst_n) begin
                if (!last_act) begin
                    chk(rdata_vld == prev_v && rdata == prev_d, "R5 output frozen", rdata, prev_d);
                end else if (sb.size() > 0 && sb[0].due == act_cnt) begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(rdata_vld, "R1 valid at due slot", {31'b0, rdata_vld}, 32'h1);
                    if (oe_n) chk(!dq_drive && rdata == '0, "R8 output disabled", rdata, 32'h0);
                    else      chk(dq_drive && rdata == e.data, "R1 R3 R9 read data", rdata, e.data);
                end else begin
                    chk(!rdata_vld, "R6 no valid outside read slot", {31'b0, rdata_vld}, 32'h0);
                end
            end
            prev_v = rdata_vld; prev_d = rdata;
        end
    end

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; hold = 0; ce0_n = 1; ce1 = 1; ce2_n = 0; adv = 0; rd_wr_n = 1;
        be_n = 4'hF; addr = '0; wdata = '0; oe_n = 0;
        repeat (3) @(negedge clk);
        chk(!rdata_vld && !dq_drive && rdata == '0, "R10 reset state", rdata, 32'h0);
        rst_n = 1;

        // R2 R4 full-word writes, then reads back to back
        for (int a = 0; a < 8; a++) wr(a, 4'h0, 32'hC0DE_0000 + a * 32'h0101_0111);
        for (int a = 0; a < 8; a++) rd(a);

        // R3 mixed order, R9 forwarding with partial lanes
        wr(8, 4'h0, 32'h8888_8888);
        rd(8);
        wr(9, 4'h0, 32'h9999_9999);
        rd(8);
        rd(9);
        wr(8, 4'b1010, 32'hAABB_CCDD);
        rd(8);
        rd(8);
        idle();
        rd(8);

        // R4 all lanes disabled
        wr(2, 4'hF, 32'hFFFF_FFFF);
        rd(2);
        // read then write to the same word
        rd(3);
        wr(3, 4'b0110, 32'h1234_5678);
        rd(3);

        // R6 each chip enable deselects; writes must not land
        cyc(0, 1, 3'b110, 0, 4'h0, 4, 32'hDEAD_0001);
        cyc(0, 1, 3'b000, 0, 4'h0, 4, 32'hDEAD_0002);
        cyc(0, 1, 3'b011, 0, 4'h0, 4, 32'hDEAD_0003);
        cyc(0, 1, 3'b011, 1, 4'hF, 4, 32'h0);
        rd(4);

        // R7 advance repeats the loaded op; ce and rd_wr_n ignored
        rd(0);
        cyc(0, 0, 3'b110, 0, 4'h0, 1, 32'h0);
        cyc(0, 0, 3'b110, 0, 4'h0, 2, 32'h0);
        wr(20, 4'h0, 32'h2020_2020);
        cyc(0, 0, 3'b110, 1, 4'h0, 21, 32'h2121_2121);
        cyc(0, 0, 3'b010, 1, 4'h0, 22, 32'h2222_2222);
        cyc(0, 0, 3'b010, 1, 4'b1100, 20, 32'h0000_ABCD);
        idle();
        cyc(0, 0, 3'b010, 1, 4'hF, 5, 32'h0);
        rd(20);
        rd(21);
        rd(22);

        // R5 hold cycles inside the pipeline
        rd(0);
        stall();
        stall();
        rd(1);
        stall();
        wr(6, 4'h0, 32'h6666_0606);
        stall();
        stall();
        rd(6);
        stall();
        rd(7);
        idle();

        // R8 output enable off while reads complete
        idle();
        oe_n = 1;
        rd(0);
        rd(1);
        idle();
        idle();
        idle();
        oe_n = 0;
        rd(1);

        repeat (5) idle();
        chk(sb.size() == 0, "R1 every read returned", sb.size(), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule